// File: doc/BRIEF.md
# Header-Mode Display List Executor

This block runs register-programming lists out of memory without processor help. Software gives it the address of a list header and pulses a start input. The engine reads the header word by word through a read port that has one read outstanding at a time. It then walks up to eight bodies named in that header. Each body is a run of 8-byte entries, and each entry holds a target register address and a value. The engine turns every entry into one write on a register-write bus.

After the last body, the header's flags decide what happens next. The engine either fetches another header on its own and runs it, or it ends the run and may signal completion with a one-cycle interrupt. This lets a whole sequence of headers, each one programming a full pass of a processing pipeline, run back to back from a single start.

Top module: `dlist_exec`

## Requirements
- R1: After synchronous reset, `busy`, `end_irq`, `reg_wr_en` and `mem_req_valid` are all low.
- R2: A `start` pulse while idle captures `start_addr` with its low three bits forced to zero. `busy` is high from the next cycle. The header is read as 19 consecutive 32-bit words from that address: word 0 is the extra-body count, words 1+2k and 2+2k are the byte length and body address of slot k (k = 0..7), word 17 is the next-header address and word 18 is the flags word.
- R3: With count value c, slots 0 through min(c,7) are processed, in ascending slot order. Slots above that limit are not touched.
- R4: A slot of length L holds floor(L/8) entries. Entry e sits at body address + 8e, with the register address in the first word and the data in the second. Entries are processed in ascending order, and each one produces exactly one `reg_wr_en` pulse carrying that address and data.
- R5: A slot whose length is below 8 (zero entries) is skipped without any memory read inside its body.
- R6: If flags bit 0 is set, then after the last slot the engine fetches the header at word 17 (low three bits ignored) and runs it without a new `start`. `busy` stays high across this step and no interrupt is raised.
- R7: If flags bit 0 is clear, the run ends and `busy` falls. If flags bit 1 is set, `end_irq` is high for exactly one cycle, in the same cycle `busy` falls. With bit 1 clear there is no pulse.
- R8: A `start` pulse while `busy` is high is ignored: the current chain goes on unchanged and no extra writes occur.
- R9: A read request holds `mem_req_valid` and a stable word-aligned `mem_req_addr` until `mem_req_ready`. No new request is made until the response to the previous one has arrived.
- R10: Register writes occur only while `busy` is high, and `busy` falls only after the final write of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_addr | input | 32 | Byte address of the first header |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 32 | Register write address |
| reg_wr_data | output | 32 | Register write data |
| busy | output | 1 | Chain in progress |
| end_irq | output | 1 | One-cycle end-of-chain interrupt |

## Verification
The bench targets these corner cases:
- A count field above seven. A design that fails to clamp it would index past the last slot.
- A slot of zero length placed between two used slots. Its body address points into a region the memory model flags, so a design that fetches it anyway is caught.
- A length that is not a multiple of eight. A design that rounds up would write a stray extra entry.
- A three-header chain whose middle header sets both flags. A design that pulses the interrupt per header instead of per chain would be seen.
- A restart attempt in the middle of a run. A design that honours it would show writes out of order or extra writes.
- Unaligned start and next-header addresses. A design that keeps the low bits would read the wrong header.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

    localparam int WORD_W      = 32;
    localparam int ENTRY_BYTES = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HDR,
        SQ_SLOT,
        SQ_ENT_A,
        SQ_ENT_D,
        SQ_ADV,
        SQ_FIN
    } seq_state_e;

    typedef struct packed {
        word_t addr;
        word_t data;
    } reg_wr_t;

    // Header addresses live on 8-byte boundaries
    function automatic word_t align8(word_t a);
        return a & ~word_t'(7);
    endfunction

    // Byte length of a body turned into a count of whole entries
    function automatic word_t entries_of(word_t len);
        return len >> 3;
    endfunction

    function automatic int hdr_words(int slots);
        return 2 * slots + 3;
    endfunction

endpackage

// File: rtl/dlx_rd_port.sv
module dlx_rd_port
    import dlx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  word_t go_addr,
    output logic  idle,
    output logic  done,
    output word_t done_data,
    output logic  mem_req_valid,
    input  logic  mem_req_ready,
    output word_t mem_req_addr,
    input  logic  mem_rsp_valid,
    input  word_t mem_rsp_data
);

    typedef enum logic [1:0] {RP_IDLE, RP_REQ, RP_WAIT} rp_state_e;

    rp_state_e st;
    word_t     addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RP_IDLE;
            addr_q <= '0;
        end else begin
            unique case (st)
                RP_IDLE: if (go) begin
                    st     <= RP_REQ;
                    addr_q <= go_addr;
                end
                RP_REQ:  if (mem_req_ready) st <= RP_WAIT;
                RP_WAIT: if (mem_rsp_valid) st <= RP_IDLE;
                default: st <= RP_IDLE;
            endcase
        end
    end

    assign idle          = (st == RP_IDLE);
    assign done          = (st == RP_WAIT) && mem_rsp_valid;
    assign done_data     = mem_rsp_data;
    assign mem_req_valid = (st == RP_REQ);
    assign mem_req_addr  = addr_q;

endmodule

// File: rtl/dlx_hdr_regs.sv
module dlx_hdr_regs
    import dlx_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int HW   = 2 * SLOTS + 3,
    localparam int IW   = $clog2(HW)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  word_t         wdata,
    output word_t         cnt,
    output word_t         next_hdr,
    output logic [1:0]    flags,
    output word_t         slot_len  [SLOTS],
    output word_t         slot_addr [SLOTS]
);

    localparam int NEXT_IDX  = 2 * SLOTS + 1;
    localparam int FLAGS_IDX = 2 * SLOTS + 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            next_hdr <= '0;
            flags    <= '0;
        end else if (we) begin
            if (idx == IW'(0))         cnt      <= wdata;
            if (idx == IW'(NEXT_IDX))  next_hdr <= wdata;
            if (idx == IW'(FLAGS_IDX)) flags    <= wdata[1:0];
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_len[k]  <= '0;
                slot_addr[k] <= '0;
            end else if (we) begin
                if (idx == IW'(1 + 2 * k)) slot_len[k]  <= wdata;
                if (idx == IW'(2 + 2 * k)) slot_addr[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dlx_seq.sv
module dlx_seq
    import dlx_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int HW   = 2 * SLOTS + 3,
    localparam int IW   = $clog2(HW),
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  word_t         start_addr,
    output logic          rd_go,
    output word_t         rd_addr,
    input  logic          rd_idle,
    input  logic          rd_done,
    input  word_t         rd_data,
    output logic          hdr_we,
    output logic [IW-1:0] hdr_idx,
    input  word_t         hdr_cnt,
    input  word_t         hdr_next,
    input  logic [1:0]    hdr_flags,
    input  word_t         slot_len  [SLOTS],
    input  word_t         slot_addr [SLOTS],
    output logic          wr_en,
    output word_t         wr_addr,
    output word_t         wr_data,
    output logic          busy,
    output logic          end_irq
);

    seq_state_e    state;
    word_t         base;
    logic [IW-1:0] widx;
    logic [SW-1:0] slot;
    word_t         ptr;
    word_t         remain;
    word_t         ent_addr;
    logic [SW-1:0] last_slot;
    word_t         cur_cnt;
    logic          need_rd;

    // Count field is "extra bodies"; anything past the table end is clamped
    always_comb begin
        if (hdr_cnt >= word_t'(SLOTS)) last_slot = SW'(SLOTS - 1);
        else                           last_slot = hdr_cnt[SW-1:0];
    end

    assign cur_cnt = entries_of(slot_len[slot]);

    always_comb begin
        need_rd = 1'b0;
        rd_addr = ptr;
        unique case (state)
            SQ_HDR: begin
                need_rd = 1'b1;
                rd_addr = base + (word_t'(widx) << 2);
            end
            SQ_ENT_A: begin
                need_rd = 1'b1;
                rd_addr = ptr;
            end
            SQ_ENT_D: begin
                need_rd = 1'b1;
                rd_addr = ptr + word_t'(4);
            end
            default: ;
        endcase
    end

    assign rd_go   = need_rd && rd_idle;
    assign hdr_we  = (state == SQ_HDR) && rd_done;
    assign hdr_idx = widx;
    assign busy    = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            base     <= '0;
            widx     <= '0;
            slot     <= '0;
            ptr      <= '0;
            remain   <= '0;
            ent_addr <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            end_irq  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            end_irq <= 1'b0;
            unique case (state)
                SQ_IDLE: if (start) begin
                    base  <= align8(start_addr);
                    widx  <= '0;
                    state <= SQ_HDR;
                end
                SQ_HDR: if (rd_done) begin
                    if (widx == IW'(HW - 1)) begin
                        slot  <= '0;
                        state <= SQ_SLOT;
                    end else begin
                        widx <= widx + IW'(1);
                    end
                end
                SQ_SLOT: begin
                    if (cur_cnt == '0) begin
                        state <= SQ_ADV;
                    end else begin
                        ptr    <= slot_addr[slot];
                        remain <= cur_cnt;
                        state  <= SQ_ENT_A;
                    end
                end
                SQ_ENT_A: if (rd_done) begin
                    ent_addr <= rd_data;
                    state    <= SQ_ENT_D;
                end
                SQ_ENT_D: if (rd_done) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ent_addr;
                    wr_data <= rd_data;
                    ptr     <= ptr + word_t'(ENTRY_BYTES);
                    remain  <= remain - word_t'(1);
                    state   <= (remain == word_t'(1)) ? SQ_ADV : SQ_ENT_A;
                end
                SQ_ADV: begin
                    if (slot == last_slot) begin
                        state <= SQ_FIN;
                    end else begin
                        slot  <= slot + SW'(1);
                        state <= SQ_SLOT;
                    end
                end
                SQ_FIN: begin
                    if (hdr_flags[0]) begin
                        base  <= align8(hdr_next);
                        widx  <= '0;
                        state <= SQ_HDR;
                    end else begin
                        end_irq <= hdr_flags[1];
                        state   <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dlist_exec.sv
module dlist_exec
    import dlx_pkg::*;
#(
    parameter int SLOTS = 8
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] start_addr,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        reg_wr_en,
    output logic [31:0] reg_wr_addr,
    output logic [31:0] reg_wr_data,
    output logic        busy,
    output logic        end_irq
);

    localparam int HW = hdr_words(SLOTS);
    localparam int IW = $clog2(HW);

    logic          rd_go, rd_idle, rd_done;
    word_t         rd_addr, rd_data;
    logic          hdr_we;
    logic [IW-1:0] hdr_idx;
    word_t         hdr_cnt, hdr_next;
    logic [1:0]    hdr_flags;
    word_t         slot_len  [SLOTS];
    word_t         slot_addr [SLOTS];
    reg_wr_t       wr;

    dlx_rd_port u_rd (
        .clk           (clk),
        .rst           (rst),
        .go            (rd_go),
        .go_addr       (rd_addr),
        .idle          (rd_idle),
        .done          (rd_done),
        .done_data     (rd_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    dlx_hdr_regs #(.SLOTS(SLOTS)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .we        (hdr_we),
        .idx       (hdr_idx),
        .wdata     (rd_data),
        .cnt       (hdr_cnt),
        .next_hdr  (hdr_next),
        .flags     (hdr_flags),
        .slot_len  (slot_len),
        .slot_addr (slot_addr)
    );

    dlx_seq #(.SLOTS(SLOTS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .rd_go      (rd_go),
        .rd_addr    (rd_addr),
        .rd_idle    (rd_idle),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .hdr_we     (hdr_we),
        .hdr_idx    (hdr_idx),
        .hdr_cnt    (hdr_cnt),
        .hdr_next   (hdr_next),
        .hdr_flags  (hdr_flags),
        .slot_len   (slot_len),
        .slot_addr  (slot_addr),
        .wr_en      (reg_wr_en),
        .wr_addr    (wr.addr),
        .wr_data    (wr.data),
        .busy       (busy),
        .end_irq    (end_irq)
    );

    assign reg_wr_addr = wr.addr;
    assign reg_wr_data = wr.data;

endmodule

// File: rtl/dlx_exec_chk.sv
module dlx_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        end_irq,
    input logic        reg_wr_en,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        end_irq |=> !end_irq);

    a_r7_irq_at_end: assert property (@(posedge clk) disable iff (rst)
        end_irq |-> !busy && $past(busy));

    a_r10_wr_busy: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> busy);

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind dlist_exec dlx_exec_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .busy          (busy),
    .end_irq       (end_irq),
    .reg_wr_en     (reg_wr_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_dlist_exec.sv
module tb_dlist_exec;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] start_addr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        reg_wr_en;
    logic [31:0] reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        busy;
    logic        end_irq;

    always #2 clk = ~clk;   // 250 MHz

    dlist_exec dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .busy(busy), .end_irq(end_irq)
    );

    logic [31:0] mem [0:4095];
    logic [63:0] expq [$];
    int    checks = 0;
    int    fails  = 0;
    int    irq_cnt;
    int    poison_hits;
    int    r9_viol;
    string ctx = "R4";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory responder ----------------
    logic [15:0] lfsr;
    logic        pend;
    logic [1:0]  cd;
    logic [31:0] paddr;

    always @(posedge clk) begin
        if (rst) begin
            lfsr          <= 16'hACE1;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            pend          <= 1'b0;
            cd            <= '0;
            paddr         <= '0;
        end else begin
            lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready <= lfsr[2] | lfsr[7];
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                if (cd == 2'd0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[paddr[13:2]];
                    pend          <= 1'b0;
                end else begin
                    cd <= cd - 2'd1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (pend) r9_viol <= r9_viol + 1;
                if (mem_req_addr >= 32'h3000) poison_hits <= poison_hits + 1;
                pend  <= 1'b1;
                paddr <= mem_req_addr;
                cd    <= {1'b0, lfsr[5]};
            end
        end
    end

    // ---------------- monitor / scoreboard ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                if (expq.size() == 0) begin
                    chk(1'b0, ctx, "unexpected write", {reg_wr_addr, reg_wr_data}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    chk({reg_wr_addr, reg_wr_data} == e, ctx, "write R4",
                        {reg_wr_addr, reg_wr_data}, e);
                end
            end
            if (end_irq) begin
                irq_cnt++;
                chk(!busy, "R7", "busy low with irq", 64'(busy), 64'h0);
            end
        end
    end

    // ---------------- driver helpers ----------------
    task automatic set_w(input int a, input logic [31:0] v);
        mem[a >> 2] = v;
    endtask

    task automatic mk_body(input int a, input int n, input int seed);
        for (int e = 0; e < n; e++) begin
            set_w(a + 8 * e,     32'h4000_0000 + 32'(seed * 256 + e * 4));
            set_w(a + 8 * e + 4, 32'(seed) * 32'h0101_0101 ^ 32'(e * 32'h9E37));
        end
    endtask

    task automatic mk_hdr(input int b, input int cnt, input int nxt, input int flags);
        set_w(b, 32'(cnt));
        for (int k = 0; k < 8; k++) begin
            set_w(b + 4 + 8 * k, 32'h0);
            set_w(b + 8 + 8 * k, 32'h3000 + 32'(k * 64));
        end
        set_w(b + 68, 32'(nxt));
        set_w(b + 72, 32'(flags));
    endtask

    task automatic set_slot(input int b, input int k, input int len, input int a);
        set_w(b + 4 + 8 * k, 32'(len));
        set_w(b + 8 + 8 * k, 32'(a));
    endtask

    // Reference walk of the chain from the requirements; pushes expected writes
    task automatic expect_chain(input int start_a, output int exp_irq);
        logic [31:0] b, cnt, len, ba, flags;
        int last;
        b = 32'(start_a) & ~32'h7;
        exp_irq = 0;
        for (int hop = 0; hop < 16; hop++) begin
            cnt  = mem[b[13:2]];
            last = (cnt > 7) ? 7 : int'(cnt);
            for (int s = 0; s <= last; s++) begin
                len = mem[(b[13:0] + 14'(4 + 8 * s)) >> 2];
                ba  = mem[(b[13:0] + 14'(8 + 8 * s)) >> 2];
                for (int e = 0; e < int'(len >> 3); e++)
                    expq.push_back({mem[(ba[13:0] + 14'(8 * e)) >> 2],
                                    mem[(ba[13:0] + 14'(8 * e + 4)) >> 2]});
            end
            flags = mem[(b[13:0] + 14'd72) >> 2];
            if (flags[0]) begin
                b = mem[(b[13:0] + 14'd68) >> 2] & ~32'h7;
            end else begin
                exp_irq = int'(flags[1]);
                break;
            end
        end
    endtask

    task automatic run(input int a, input string tag, input string irq_tag,
                       input bit restart, input int other_a);
        int exp_irq;
        int w;
        expect_chain(a, exp_irq);
        ctx         = tag;
        irq_cnt     = 0;
        poison_hits = 0;
        r9_viol     = 0;
        @(negedge clk);
        start      = 1'b1;
        start_addr = 32'(a);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'h1);
        if (restart) begin
            repeat (12) @(negedge clk);
            chk(busy == 1'b1, "R8", "still busy at restart", 64'(busy), 64'h1);
            start      = 1'b1;
            start_addr = 32'(other_a);
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (busy && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 20000, "R10", "busy fell", 64'(w), 64'h0);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, tag, "writes missing R10", 64'(expq.size()), 64'h0);
        chk(irq_cnt == exp_irq, irq_tag, "irq count", 64'(irq_cnt), 64'(exp_irq));
        chk(busy == 1'b0, tag, "idle after run", 64'(busy), 64'h0);
        chk(poison_hits == 0, "R5", "reads in skipped body", 64'(poison_hits), 64'h0);
        chk(r9_viol == 0, "R9", "request while outstanding", 64'(r9_viol), 64'h0);
        expq.delete();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        rst        = 1'b1;
        start      = 1'b0;
        start_addr = '0;
        irq_cnt    = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0,          "R1", "busy",      64'(busy), 64'h0);
        chk(end_irq == 1'b0,       "R1", "end_irq",   64'(end_irq), 64'h0);
        chk(reg_wr_en == 1'b0,     "R1", "reg_wr_en", 64'(reg_wr_en), 64'h0);
        chk(mem_req_valid == 1'b0, "R1", "req_valid", 64'(mem_req_valid), 64'h0);

        // R4: single body, three entries, interrupt
        mk_hdr(32'h100, 0, 0, 2);
        set_slot(32'h100, 0, 24, 32'h1000);
        mk_body(32'h1000, 3, 1);

        // R3 / R5: count 2, middle slot empty, odd length, slot 3 must not run
        mk_hdr(32'h200, 2, 0, 2);
        set_slot(32'h200, 0, 16, 32'h1100);
        set_slot(32'h200, 2, 20, 32'h1200);
        set_slot(32'h200, 3, 8,  32'h1300);
        mk_body(32'h1100, 2, 2);
        mk_body(32'h1200, 2, 3);
        mk_body(32'h1300, 1, 4);

        // R3 clamp: count 12, all eight slots used
        mk_hdr(32'h300, 12, 0, 2);
        for (int k = 0; k < 8; k++) begin
            set_slot(32'h300, k, 8 + 8 * (k % 2), 32'h1400 + k * 64);
            mk_body(32'h1400 + k * 64, 2, 10 + k);
        end

        // R6 chain: 0x400 -> 0x500 (both flags) -> 0x600 (irq)
        mk_hdr(32'h400, 1, 32'h505, 1);
        set_slot(32'h400, 0, 8,  32'h1800);
        set_slot(32'h400, 1, 16, 32'h1840);
        mk_body(32'h1800, 1, 20);
        mk_body(32'h1840, 2, 21);
        mk_hdr(32'h500, 0, 32'h600, 3);
        set_slot(32'h500, 0, 24, 32'h1880);
        mk_body(32'h1880, 3, 22);
        mk_hdr(32'h600, 0, 0, 2);
        set_slot(32'h600, 0, 8, 32'h18C0);
        mk_body(32'h18C0, 1, 23);

        // R7: no flags, no interrupt
        mk_hdr(32'h700, 0, 0, 0);
        set_slot(32'h700, 0, 16, 32'h1900);
        mk_body(32'h1900, 2, 30);

        // R5: every slot empty, interrupt only
        mk_hdr(32'h800, 3, 0, 2);

        run(32'h100, "R4", "R7", 1'b0, 0);
        run(32'h200, "R3 R5", "R7", 1'b0, 0);
        run(32'h300, "R3", "R7", 1'b0, 0);
        run(32'h400, "R6", "R6", 1'b0, 0);
        run(32'h700, "R7", "R7", 1'b0, 0);
        run(32'h300, "R8", "R8", 1'b1, 32'h100);
        run(32'h203, "R2", "R7", 1'b0, 0);
        run(32'h800, "R5", "R7", 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule